// File: doc/BRIEF.md
# Polled Command Frame Transmitter

This engine sends one command to a security coprocessor that exposes four byte-wide registers: a transmit FIFO, a receive FIFO, a status register and a control register. A one-cycle `start` pulse gives it a 32-bit payload length. The engine first writes a quiet value to the control register. It then empties stale data from both FIFOs. After that it streams a framed command byte by byte into the transmit FIFO. Before each byte it polls the status register until the transmit-empty flag is set. Payload bytes come from an external command buffer through a combinational read port (`buf_addr` out, `buf_data` back in the same cycle). Register reads are also combinational: `bus_rdata` is sampled at the end of the cycle in which `bus_rd` is high. `poll_gap` sets how many idle cycles follow each status read that still shows the FIFO busy.

The frame has three parts, sent in this order. An outer header of four bytes: `0x01`, `0x04`, then the high and low bytes of (length + 6). An inner header of six bytes: `0x01`, `0x0B`, then the 32-bit length, most significant byte first. Then the payload, read from buffer addresses 0 to length-1.

The controller has ten states, one step per cycle:
- IDLE goes to CMD on `start`.
- CMD writes the quiet value, then goes to WFLUSH.
- WFLUSH reads the transmit FIFO and stays until its exit condition, then goes to RFL_DATA.
- RFL_DATA reads the receive FIFO and goes to RFL_STAT. RFL_STAT reads status and goes back to RFL_DATA while receive data is available. It goes to POLL when the flag is clear, or to FAIL when its limit is reached.
- POLL reads status. It goes to SEND when the transmit FIFO is empty. Otherwise it goes to GAP, or stays in POLL when the gap is zero, or goes to FAIL when its limit is reached.
- GAP waits `poll_gap` cycles, then returns to POLL.
- SEND writes one frame byte. It goes back to POLL, or to DONE after the last byte.
- DONE and FAIL each last one cycle, then return to IDLE.

Top module: `cmd_frame_tx`

## Requirements
- R1: After reset, and whenever `busy` is low, `done`, `timeout`, `bus_rd` and `bus_wr` are all low.
- R2: In the cycle after `start`, the first bus access of a frame writes `0x41` to register offset 3.
- R3: The transmit-FIFO flush reads offset 0 every cycle. It stops after the read that returns `0xFF` for the sixth time, or after 4096 reads, whichever comes first. Reaching the read limit is not an error.
- R4: The receive-FIFO flush alternates a read of offset 1 with a read of offset 2. It repeats this pair while status bit 7 is set, and it always makes at least one pair.
- R5: The first four bytes written to offset 0 are `0x01`, `0x04`, then bits 15:8 and bits 7:0 of (length + 6).
- R6: The next six bytes are `0x01`, `0x0B`, then the length, bytes 3, 2, 1, 0 in that order.
- R7: The payload follows in buffer-address order, 0 to length-1. The total number of writes to offset 0 is length + 10.
- R8: A write to offset 0 happens only after a status read (offset 2) with bit 0 set, and no other write to offset 0 comes between that read and the write.
- R9: After a status read during polling that shows bit 0 clear, exactly `poll_gap` cycles without bus access pass before the next status read.
- R10: 5000 consecutive polling reads with bit 0 clear end the frame with a one-cycle `timeout`. No further write follows, and the engine returns to idle.
- R11: 5000 flush iterations that all show status bit 7 set end the frame with a one-cycle `timeout`, before any write to offset 0.
- R12: `done` is a one-cycle pulse in the cycle right after the last payload write. `done` and `timeout` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request to send a frame; accepted only in IDLE |
| frame_len | input | 32 | Payload length in bytes, captured on `start` |
| poll_gap | input | GAP_W | Idle cycles after each busy status read, captured on `start` |
| buf_addr | output | AW | Command buffer read address |
| buf_data | input | 8 | Command buffer byte at `buf_addr`, same cycle |
| bus_addr | output | 2 | Register offset: 0 TX FIFO, 1 RX FIFO, 2 status, 3 control |
| bus_wdata | output | 8 | Register write data |
| bus_wr | output | 1 | Register write strobe |
| bus_rd | output | 1 | Register read strobe |
| bus_rdata | input | 8 | Register read data, same cycle as `bus_rd` |
| busy | output | 1 | High whenever the engine is not in IDLE |
| done | output | 1 | One-cycle pulse after the frame's last byte |
| timeout | output | 1 | One-cycle pulse when a wait or flush gives up |

## Verification
The assertions check on every cycle that:
- the bus is silent while idle;
- a frame opens with the control write;
- every transmit-FIFO write is covered by an earlier empty-flag read;
- a busy poll is followed by a quiet cycle when a gap is set;
- the retry counter stays in range;
- `done` is a single pulse that never coincides with `timeout`.

The byte content and order of both headers and the payload, the flush read counts (including the 4096-read limit), the exact poll spacing, and both timeout paths can only be shown by the bench. It runs scenarios against a register-level model of the coprocessor whose FIFO contents and busy periods are set per frame.

// File: rtl/cft_pkg.sv
package cft_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_CMD,
        S_WFLUSH,
        S_RFL_DATA,
        S_RFL_STAT,
        S_POLL,
        S_GAP,
        S_SEND,
        S_DONE,
        S_FAIL
    } cft_state_e;

    localparam logic [1:0] OFF_WFIFO = 2'd0;
    localparam logic [1:0] OFF_RFIFO = 2'd1;
    localparam logic [1:0] OFF_STAT  = 2'd2;
    localparam logic [1:0] OFF_CMD   = 2'd3;

    localparam logic [7:0] CMD_QUIET = 8'h41;
    localparam logic [7:0] HDR_VER   = 8'h01;
    localparam logic [7:0] HDR_DATA  = 8'h04;
    localparam logic [7:0] HDR_CHAN  = 8'h0B;
    localparam logic [7:0] FILL_BYTE = 8'hFF;

    localparam int HDR_BYTES = 10;
    localparam int XFE_BIT   = 0;
    localparam int RDA_BIT   = 7;

endpackage

// File: rtl/cft_count.sv
module cft_count #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (clr) begin
            q <= '0;
        end else if (inc) begin
            q <= q + W'(1);
        end
    end
endmodule

// File: rtl/cft_frame_mux.sv
module cft_frame_mux
    import cft_pkg::*;
#(
    parameter int AW = 12
) (
    input  logic [33:0]   idx,
    input  logic [31:0]   len,
    input  logic [7:0]    buf_data,
    output logic [AW-1:0] buf_addr,
    output logic [7:0]    byte_o
);
    logic [15:0] outer_len;
    logic [33:0] pay_off;
    logic        unused_hi;

    assign outer_len = len[15:0] + 16'd6;
    assign pay_off   = idx - 34'(HDR_BYTES);
    assign buf_addr  = pay_off[AW-1:0];
    assign unused_hi = ^pay_off[33:AW];

    always_comb begin
        if (idx < 34'(HDR_BYTES)) begin
            unique case (idx[3:0])
                4'd0:    byte_o = HDR_VER;
                4'd1:    byte_o = HDR_DATA;
                4'd2:    byte_o = outer_len[15:8];
                4'd3:    byte_o = outer_len[7:0];
                4'd4:    byte_o = HDR_VER;
                4'd5:    byte_o = HDR_CHAN;
                4'd6:    byte_o = len[31:24];
                4'd7:    byte_o = len[23:16];
                4'd8:    byte_o = len[15:8];
                default: byte_o = len[7:0];
            endcase
        end else begin
            byte_o = buf_data;
        end
    end
endmodule

// File: rtl/cmd_frame_tx.sv
module cmd_frame_tx
    import cft_pkg::*;
#(
    parameter int AW        = 12,
    parameter int GAP_W     = 16,
    parameter int MAX_TRIES = 5000,
    parameter int WF_READS  = 4096,
    parameter int FF_HITS   = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [31:0]      frame_len,
    input  logic [GAP_W-1:0] poll_gap,
    output logic [AW-1:0]    buf_addr,
    input  logic [7:0]       buf_data,
    output logic [1:0]       bus_addr,
    output logic [7:0]       bus_wdata,
    output logic             bus_wr,
    output logic             bus_rd,
    input  logic [7:0]       bus_rdata,
    output logic             busy,
    output logic             done,
    output logic             timeout
);
    localparam int LIM = (MAX_TRIES > WF_READS) ? MAX_TRIES : WF_READS;
    localparam int TW  = $clog2(LIM + 1);
    localparam int HW  = $clog2(FF_HITS + 1);

    cft_state_e state, nxt;

    logic [31:0]      len_q;
    logic [GAP_W-1:0] gap_q;
    logic [TW-1:0]    tries;
    logic [HW-1:0]    hits;
    logic [GAP_W-1:0] gap_cnt;
    logic [33:0]      fidx;
    logic [33:0]      last_idx;
    logic [7:0]       frame_byte;
    logic             rd_fill;

    logic t_clr, t_inc, h_clr, h_inc, g_clr, g_inc, f_clr, f_inc;

    assign last_idx = {2'b00, len_q} + 34'(HDR_BYTES - 1);
    assign rd_fill  = (bus_rdata == FILL_BYTE);

    cft_count #(.W(TW)) u_tries (
        .clk(clk), .rst_n(rst_n), .clr(t_clr), .inc(t_inc), .q(tries)
    );
    cft_count #(.W(HW)) u_hits (
        .clk(clk), .rst_n(rst_n), .clr(h_clr), .inc(h_inc), .q(hits)
    );
    cft_count #(.W(GAP_W)) u_gap (
        .clk(clk), .rst_n(rst_n), .clr(g_clr), .inc(g_inc), .q(gap_cnt)
    );
    cft_count #(.W(34)) u_fidx (
        .clk(clk), .rst_n(rst_n), .clr(f_clr), .inc(f_inc), .q(fidx)
    );

    cft_frame_mux #(.AW(AW)) u_mux (
        .idx(fidx), .len(len_q), .buf_data(buf_data),
        .buf_addr(buf_addr), .byte_o(frame_byte)
    );

    // State register and captured request
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_IDLE;
            len_q <= '0;
            gap_q <= '0;
        end else begin
            state <= nxt;
            if (state == S_IDLE && start) begin
                len_q <= frame_len;
                gap_q <= poll_gap;
            end
        end
    end

    // Next state and counter control
    always_comb begin
        nxt   = state;
        t_clr = 1'b0; t_inc = 1'b0;
        h_clr = 1'b0; h_inc = 1'b0;
        g_clr = 1'b0; g_inc = 1'b0;
        f_clr = 1'b0; f_inc = 1'b0;
        unique case (state)
            S_IDLE: begin
                t_clr = 1'b1; h_clr = 1'b1; f_clr = 1'b1;
                if (start) nxt = S_CMD;
            end
            S_CMD: nxt = S_WFLUSH;
            S_WFLUSH: begin
                t_inc = 1'b1;
                h_inc = rd_fill;
                if ((rd_fill && hits == HW'(FF_HITS - 1)) ||
                    tries == TW'(WF_READS - 1)) begin
                    t_clr = 1'b1;
                    nxt   = S_RFL_DATA;
                end
            end
            S_RFL_DATA: nxt = S_RFL_STAT;
            S_RFL_STAT: begin
                if (!bus_rdata[RDA_BIT]) begin
                    t_clr = 1'b1;
                    nxt   = S_POLL;
                end else if (tries == TW'(MAX_TRIES - 1)) begin
                    nxt = S_FAIL;
                end else begin
                    t_inc = 1'b1;
                    nxt   = S_RFL_DATA;
                end
            end
            S_POLL: begin
                if (bus_rdata[XFE_BIT]) begin
                    t_clr = 1'b1;
                    nxt   = S_SEND;
                end else if (tries == TW'(MAX_TRIES - 1)) begin
                    nxt = S_FAIL;
                end else begin
                    t_inc = 1'b1;
                    if (gap_q != '0) begin
                        g_clr = 1'b1;
                        nxt   = S_GAP;
                    end
                end
            end
            S_GAP: begin
                g_inc = 1'b1;
                if (gap_cnt == gap_q - GAP_W'(1)) nxt = S_POLL;
            end
            S_SEND: begin
                f_inc = 1'b1;
                nxt   = (fidx == last_idx) ? S_DONE : S_POLL;
            end
            S_DONE:  nxt = S_IDLE;
            S_FAIL:  nxt = S_IDLE;
            default: nxt = S_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        bus_rd    = 1'b0;
        bus_wr    = 1'b0;
        bus_addr  = OFF_WFIFO;
        bus_wdata = 8'h00;
        unique case (state)
            S_CMD:      begin bus_wr = 1'b1; bus_addr = OFF_CMD; bus_wdata = CMD_QUIET; end
            S_WFLUSH:   begin bus_rd = 1'b1; bus_addr = OFF_WFIFO; end
            S_RFL_DATA: begin bus_rd = 1'b1; bus_addr = OFF_RFIFO; end
            S_RFL_STAT: begin bus_rd = 1'b1; bus_addr = OFF_STAT; end
            S_POLL:     begin bus_rd = 1'b1; bus_addr = OFF_STAT; end
            S_SEND:     begin bus_wr = 1'b1; bus_addr = OFF_WFIFO; bus_wdata = frame_byte; end
            default:    ;
        endcase
        busy    = (state != S_IDLE);
        done    = (state == S_DONE);
        timeout = (state == S_FAIL);
    end

    // Tracks whether an empty-flag read has been seen since the last FIFO write
    logic xfe_seen;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            xfe_seen <= 1'b0;
        end else if (bus_wr && bus_addr == OFF_WFIFO) begin
            xfe_seen <= 1'b0;
        end else if (bus_rd && bus_addr == OFF_STAT && bus_rdata[XFE_BIT]) begin
            xfe_seen <= 1'b1;
        end
    end

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!bus_rd && !bus_wr && !done && !timeout)); // R1
    AST_CMD_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (bus_wr && bus_addr == OFF_CMD && bus_wdata == CMD_QUIET)); // R2
    AST_SEND_AFTER_XFE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFF_WFIFO) |-> xfe_seen); // R8
    AST_GAP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_POLL && !bus_rdata[XFE_BIT] && gap_q != '0 &&
         tries != TW'(MAX_TRIES - 1)) |=> (!bus_rd && !bus_wr)); // R9
    AST_TRIES_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        tries <= TW'(LIM - 1)); // R10
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R12
    AST_END_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && timeout)); // R12

endmodule

// File: tb/cmd_frame_tx_tb_top.sv
`timescale 1ns/1ps
module cmd_frame_tx_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] frame_len = '0;
    logic [15:0] poll_gap = '0;
    logic [11:0] buf_addr;
    logic [7:0]  buf_data;
    logic [1:0]  bus_addr;
    logic [7:0]  bus_wdata;
    logic        bus_wr, bus_rd;
    logic [7:0]  bus_rdata;
    logic        busy, done, timeout;

    always #10 clk = ~clk;

    cmd_frame_tx dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .frame_len(frame_len),
        .poll_gap(poll_gap), .buf_addr(buf_addr), .buf_data(buf_data),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_rdata(bus_rdata), .busy(busy), .done(done),
        .timeout(timeout)
    );

    logic [7:0] pay [0:511];
    assign buf_data = pay[buf_addr[8:0]];

    // Coprocessor model
    int cfg_junk = 0, cfg_rf = 0, busy_max = 0;
    bit cfg_xst = 0, cfg_rst = 0, load = 0;
    int m_junk = 0, m_rf = 0, m_busy = 0;
    bit m_xst = 0, m_rst = 0;

    always @(posedge clk) begin
        if (load) begin
            m_junk <= cfg_junk; m_rf <= cfg_rf; m_busy <= 0;
            m_xst <= cfg_xst; m_rst <= cfg_rst;
        end else begin
            if (bus_rd && bus_addr == 2'd0 && m_junk > 0) m_junk <= m_junk - 1;
            if (bus_rd && bus_addr == 2'd1 && m_rf > 0) m_rf <= m_rf - 1;
            if (bus_rd && bus_addr == 2'd2 && m_busy > 0) m_busy <= m_busy - 1;
            if (bus_wr && bus_addr == 2'd0) m_busy <= $urandom_range(busy_max, 0);
        end
    end

    always_comb begin
        case (bus_addr)
            2'd0:    bus_rdata = (m_junk > 0) ? 8'h5A : 8'hFF;
            2'd1:    bus_rdata = 8'h33;
            2'd2:    bus_rdata = {(m_rf > 0) || m_rst, 6'b0, !m_xst && (m_busy == 0)};
            default: bus_rdata = 8'h00;
        endcase
    end

    // Bus monitor
    bit mon_clr = 0;
    int cyc = 0, nw = 0, n0 = 0, n1 = 0, n2 = 0, viol = 0, gviol = 0;
    int ndone = 0, nto = 0, done_cyc = 0, last_wr_cyc = 0, gap_from = 0;
    bit gap_pend = 0;
    logic [1:0] wa [0:1023];
    logic [7:0] wd [0:1023];

    always @(negedge clk) begin
        cyc = cyc + 1;
        if (mon_clr) begin
            nw = 0; n0 = 0; n1 = 0; n2 = 0; viol = 0; gviol = 0;
            ndone = 0; nto = 0; gap_pend = 0;
        end else begin
            if (bus_wr) begin
                if (nw < 1024) begin wa[nw] = bus_addr; wd[nw] = bus_wdata; end
                nw = nw + 1;
                if (bus_addr == 2'd0) begin
                    last_wr_cyc = cyc;
                    if (m_xst || m_busy != 0) viol = viol + 1;
                end
                if (gap_pend) gviol = gviol + 1;
            end
            if (bus_rd) begin
                if (bus_addr == 2'd0) n0 = n0 + 1;
                if (bus_addr == 2'd1) n1 = n1 + 1;
                if (bus_addr == 2'd2) begin
                    n2 = n2 + 1;
                    if (gap_pend && (cyc - gap_from) != int'(poll_gap) + 1) gviol = gviol + 1;
                    gap_pend = !bus_rdata[0];
                    gap_from = cyc;
                end else if (gap_pend) begin
                    gviol = gviol + 1;
                end
            end
            if (done) begin ndone = ndone + 1; done_cyc = cyc; end
            if (timeout) nto = nto + 1;
        end
    end

    int nchk = 0, nerr = 0;

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_byte(input int i, input logic [31:0] n);
        logic [31:0] t;
        t = n + 32'd6;
        case (i)
            0: return 8'h01;
            1: return 8'h04;
            2: return t[15:8];
            3: return t[7:0];
            4: return 8'h01;
            5: return 8'h0B;
            6: return n[31:24];
            7: return n[23:16];
            8: return n[15:8];
            9: return n[7:0];
            default: return pay[i - 10];
        endcase
    endfunction

    task automatic run_frame(input int len, input int junk, input int rf, input int bmax,
                             input int gap, input bit xst, input bit rst);
        int k;
        int mm5, mm6, mm7, expw0;
        for (int i = 0; i < 512; i++) pay[i] = 8'($urandom);
        @(negedge clk);
        cfg_junk = junk; cfg_rf = rf; busy_max = bmax; cfg_xst = xst; cfg_rst = rst;
        frame_len = len; poll_gap = 16'(gap);
        load = 1; mon_clr = 1;
        @(negedge clk); #1;
        load = 0; mon_clr = 0; start = 1;
        @(negedge clk); #1;
        start = 0;
        k = 0;
        while (ndone == 0 && nto == 0 && k < 40000) begin
            @(negedge clk); #1;
            k++;
        end
        repeat (3) @(negedge clk);
        #1;
        check(nw > 0 && wa[0] == 2'd3 && wd[0] == 8'h41, "R2 control write first",
              longint'(wd[0]), 65);
        if (!xst && !rst) begin
            check(n0 == ((junk + 6 < 4096) ? junk + 6 : 4096), "R3 tx flush reads",
                  n0, (junk + 6 < 4096) ? junk + 6 : 4096);
            check(n1 == ((rf > 1) ? rf : 1), "R4 rx flush reads", n1, (rf > 1) ? rf : 1);
            mm5 = 0; mm6 = 0; mm7 = 0;
            for (int i = 0; i < len + 10 && i + 1 < nw && i + 1 < 1024; i++) begin
                if (wa[i+1] != 2'd0 || wd[i+1] != exp_byte(i, 32'(len))) begin
                    if (i < 4) mm5++; else if (i < 10) mm6++; else mm7++;
                end
            end
            check(mm5 == 0, "R5 outer header mismatches", mm5, 0);
            check(mm6 == 0, "R6 inner header mismatches", mm6, 0);
            check(mm7 == 0 && nw == len + 11, "R7 payload mismatches/writes", nw, len + 11);
            check(viol == 0, "R8 writes without empty flag", viol, 0);
            check(gviol == 0, "R9 poll spacing violations", gviol, gap);
            check(ndone == 1 && nto == 0 && done_cyc == last_wr_cyc + 1,
                  "R12 done pulse timing", done_cyc - last_wr_cyc, 1);
        end else if (xst) begin
            expw0 = 0;
            for (int i = 1; i < nw && i < 1024; i++) if (wa[i] == 2'd0) expw0++;
            check(nto == 1 && ndone == 0 && expw0 == 0 && !busy, "R10 poll timeout", nto, 1);
            check(n2 == 1 + 5000, "R10 status reads before timeout", n2, 5001);
        end else begin
            expw0 = 0;
            for (int i = 1; i < nw && i < 1024; i++) if (wa[i] == 2'd0) expw0++;
            check(nto == 1 && ndone == 0 && expw0 == 0 && !busy, "R11 flush timeout", nto, 1);
            check(n1 == 5000, "R11 flush iterations", n1, 5000);
        end
    endtask

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        #1;
        check(!busy && !done && !timeout && !bus_rd && !bus_wr, "R1 reset state",
              longint'({busy, done, timeout, bus_rd, bus_wr}), 0);
        rst_n = 1;
        repeat (2) @(negedge clk);
        #1;
        check(!busy && !bus_rd && !bus_wr, "R1 idle after reset", busy, 0);
        // directed corners
        run_frame(1, 0, 0, 0, 0, 0, 0);
        run_frame(0, 2, 1, 1, 1, 0, 0);
        run_frame(300, 0, 3, 1, 0, 0, 0);
        run_frame(4, 5000, 0, 0, 0, 0, 0);
        run_frame(5, 1, 0, 2, 3, 0, 0);
        run_frame(3, 0, 0, 0, 0, 1, 0);
        run_frame(3, 0, 0, 0, 0, 0, 1);
        // recovery after timeouts plus random mix
        for (int r = 0; r < 6; r++) begin
            run_frame($urandom_range(40, 1), $urandom_range(12, 0), $urandom_range(4, 0),
                      $urandom_range(3, 0), $urandom_range(3, 0), 0, 0);
        end
        $display("  Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("  Result: errors=%0d of %0d checks", nerr + 1, nchk + 1);
        $finish;
    end

endmodule